// File: doc/BRIEF.md
# Flag-Producing Arithmetic and Logic Unit

This block is the purely combinational execute stage of a single-cycle 32-bit processor. It takes two operands, `op_a` and `op_b`, and a five-bit function code. It returns one result word and four condition flags: negative, zero, signed overflow and carry-out. One function code selects a sum or a difference, a bitwise operation, a shift, or a less-than test. The control decoder drives the function code straight from the opcode.

Shifts move `op_b` by the count held in the low five bits of `op_a`. This matches the register-specified and constant-specified shift forms, in which the shift count arrives on the A side. The less-than test uses no separate comparator. The unit forms A minus B and builds the answer from the difference flags: signed less-than is N XOR V, and unsigned less-than is the inverse of the carry. The answer is then written as a zero-extended word, so a set-on-less-than instruction can store it directly.

Top module: `alu32_flags`

## Requirements
- R1: The function code `fn[4:0]` has five fields: `fn[4]` is the subtract bit, `fn[3:2]` is the two-bit selector, `fn[1]` is the shift enable and `fn[0]` is the math enable. The result depends only on these fields as described in R2 to R7.
- R2: When `fn[0]=1`, `fn[1]=0` and `fn[4]=0`, the result is `op_a + op_b` modulo 2^32. `flag_c` is the carry out of bit 31.
- R3: When `fn[0]=1`, `fn[1]=0` and `fn[4]=1`, the result is `op_a - op_b` modulo 2^32. The unit computes it as A plus the inverted B plus one, so `flag_c` is 1 exactly when `op_a >= op_b` taken as unsigned values.
- R4: `flag_v` is 1 exactly when the signed sum (R2) or the signed difference (R3, R7) of the operands falls outside the 32-bit two's-complement range.
- R5: When `fn[0]=0` and `fn[1]=0`, the selector `fn[3:2]` chooses the bitwise operation: 00 is AND, 01 is OR, 10 is XOR and 11 is NOR. The subtract bit has no effect on the result.
- R6: When `fn[0]=0` and `fn[1]=1`, the unit shifts `op_b` by `op_a[4:0]` places. Selector 00 or 10 shifts left, 01 shifts right logically and 11 shifts right arithmetically. `op_a[31:5]` has no effect on the result.
- R7: When `fn[0]=1` and `fn[1]=1`, the unit always subtracts, whatever the subtract bit. The result is zero-extended. Its bit 0 is signed less-than (N XOR V of the difference) when `fn[2]=0`, and unsigned less-than (NOT C of the difference) when `fn[2]=1`.
- R8: For every function code, `flag_z` is 1 exactly when the result is zero, and `flag_n` equals result bit 31.
- R9: For every function code, `flag_v` and `flag_c` come from the adder. The adder adds when `fn[4]=0` and subtracts when `fn[4]=1` or when the compare of R7 is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand; bits [4:0] give the shift count |
| op_b | input | 32 | Second operand; the value that is shifted |
| fn | input | 5 | Function code {sub, sel[1:0], shift, math} |
| result | output | 32 | Selected result word |
| flag_n | output | 1 | Result bit 31 |
| flag_z | output | 1 | Result is zero |
| flag_v | output | 1 | Signed overflow of the adder |
| flag_c | output | 1 | Carry out of the adder |

## Verification
Two functions can fall in the same cycle: the adder's overflow and carry are produced while the result comes from another unit. This happens during a shift, a bitwise operation or a compare. To provoke it, the bench sweeps all 32 function codes. It uses operands built around the sign boundary (0x7FFFFFFF, 0x80000000, all ones) and shift counts whose upper bits are set. In every cycle it compares the result and all four flags against a behavioural model that works from wide integer arithmetic and native shift operators. This confirms that the flags follow R9 whichever unit owns the result, and that a compare reads the difference flags rather than the sum.

// File: rtl/alu32_pkg.sv
package alu32_pkg;

  // Field layout of the function code, most significant first.
  typedef struct packed {
    logic       sub;
    logic [1:0] sel;
    logic       shift;
    logic       math;
  } alu_fn_t;

  localparam int unsigned FN_BITS = 5;

  typedef enum logic [1:0] {
    SEL_AND = 2'b00,
    SEL_OR  = 2'b01,
    SEL_XOR = 2'b10,
    SEL_NOR = 2'b11
  } logic_sel_e;

endpackage

// File: rtl/alu32_adder.sv
module alu32_adder #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             do_sub,
  output logic [WIDTH-1:0] sum,
  output logic             carry,
  output logic             ovf
);

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   wide;

  // A - B is formed as A + ~B + 1.
  assign b_eff = b ^ {WIDTH{do_sub}};
  assign wide  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, do_sub};
  assign sum   = wide[WIDTH-1:0];
  assign carry = wide[WIDTH];
  // Overflow: both addends share a sign that differs from the sum's sign.
  assign ovf   = (a[WIDTH-1] == b_eff[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1]);

endmodule

// File: rtl/alu32_shifter.sv
module alu32_shifter #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned SHW  = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] value,
  input  logic [SHW-1:0]   amount,
  input  logic             go_right,
  input  logic             arith,
  output logic [WIDTH-1:0] shifted
);

  logic [WIDTH-1:0] rev_in;
  logic [WIDTH-1:0] rev_out;
  logic [WIDTH-1:0] right;
  logic             fill;

  // Left shift reuses the right shifter on bit-reversed data.
  for (genvar i = 0; i < WIDTH; i++) begin : g_rev
    assign rev_in[i]  = value[WIDTH-1-i];
    assign rev_out[i] = right[WIDTH-1-i];
  end

  logic [WIDTH-1:0] src;
  assign src  = go_right ? value : rev_in;
  assign fill = go_right & arith & value[WIDTH-1];

  always_comb begin
    right = src;
    for (int s = 0; s < SHW; s++) begin
      if (amount[s]) begin
        right = (right >> (1 << s)) | ({WIDTH{fill}} << (WIDTH - (1 << s)));
      end
    end
  end

  assign shifted = go_right ? right : rev_out;

endmodule

// File: rtl/alu32_logic.sv
module alu32_logic #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0]          a,
  input  logic [WIDTH-1:0]          b,
  input  alu32_pkg::logic_sel_e     sel,
  output logic [WIDTH-1:0]          y
);

  always_comb begin
    unique case (sel)
      alu32_pkg::SEL_AND: y = a & b;
      alu32_pkg::SEL_OR:  y = a | b;
      alu32_pkg::SEL_XOR: y = a ^ b;
      alu32_pkg::SEL_NOR: y = ~(a | b);
      default:            y = '0;
    endcase
  end

endmodule

// File: rtl/alu32_flags.sv
module alu32_flags #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned SHW  = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [4:0]       fn,
  output logic [WIDTH-1:0] result,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_v,
  output logic             flag_c
);

  import alu32_pkg::*;

  alu_fn_t          f;
  logic             is_cmp;
  logic             do_sub;
  logic [WIDTH-1:0] sum;
  logic             carry;
  logic             ovf;
  logic [WIDTH-1:0] shifted;
  logic [WIDTH-1:0] bitwise;
  logic             less;

  assign f      = alu_fn_t'(fn);
  assign is_cmp = f.math & f.shift;
  assign do_sub = f.sub | is_cmp;

  alu32_adder #(.WIDTH(WIDTH)) u_add (
    .a(op_a), .b(op_b), .do_sub(do_sub),
    .sum(sum), .carry(carry), .ovf(ovf)
  );

  alu32_shifter #(.WIDTH(WIDTH)) u_shf (
    .value(op_b), .amount(op_a[SHW-1:0]),
    .go_right(f.sel[0]), .arith(f.sel[1]),
    .shifted(shifted)
  );

  alu32_logic #(.WIDTH(WIDTH)) u_log (
    .a(op_a), .b(op_b), .sel(logic_sel_e'(f.sel)), .y(bitwise)
  );

  // Less-than from difference flags: signed N^V, unsigned ~C.
  assign less = f.sel[0] ? ~carry : (sum[WIDTH-1] ^ ovf);

  always_comb begin
    unique case ({f.math, f.shift})
      2'b10:   result = sum;
      2'b11:   result = {{(WIDTH-1){1'b0}}, less};
      2'b01:   result = shifted;
      default: result = bitwise;
    endcase
  end

  assign flag_n = result[WIDTH-1];
  assign flag_z = ~|result;
  assign flag_v = ovf;
  assign flag_c = carry;

endmodule

// File: rtl/alu32_flags_chk.sv
module alu32_flags_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [4:0]       fn,
  input logic [WIDTH-1:0] result,
  input logic             flag_n,
  input logic             flag_z,
  input logic             flag_v,
  input logic             flag_c
);

  always_comb begin
    if (!$isunknown({op_a, op_b, fn})) begin
      if (fn[0] && fn[1]) begin
        AST_CMP_ZEXT: assert (result[WIDTH-1:1] == '0 && !flag_n)
          else $error("compare result not zero-extended"); // R7
      end
      if (!fn[0] && fn[1] && op_a[4:0] == 5'd0) begin
        AST_SHIFT_NONE: assert (result == op_b)
          else $error("zero-count shift altered value"); // R6
      end
      if (fn[0] && !fn[1] && fn[4] && op_a == op_b) begin
        AST_SUB_SELF: assert (flag_z && flag_c && !flag_v)
          else $error("self subtraction flags wrong"); // R3
      end
      if (fn == 5'b00000) begin
        AST_AND_SUBSET: assert ((result & ~op_a) == '0 && (result & ~op_b) == '0)
          else $error("AND produced bits outside operands"); // R5
      end
      if (fn[0] && !fn[1] && !fn[4] && op_b == '0) begin
        AST_ADD_IDENT: assert (result == op_a && !flag_v && !flag_c)
          else $error("adding zero changed operand"); // R2
      end
    end
  end

endmodule

bind alu32_flags alu32_flags_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_alu32_flags.sv
module sim_alu32_flags;

  localparam time CLK_PERIOD = 10ns;

  logic        clk;
  logic        rst_n;
  logic [31:0] op_a, op_b;
  logic [4:0]  fn;
  logic [31:0] result;
  logic        flag_n, flag_z, flag_v, flag_c;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  alu32_flags u0 (
    .op_a(op_a), .op_b(op_b), .fn(fn), .result(result),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference built from wide integer arithmetic.
  function automatic void model(input logic [31:0] a, input logic [31:0] b,
                                input logic [4:0] f, output logic [31:0] r,
                                output logic v, output logic c);
    bit sub;
    longint sa, sb, s;
    logic [32:0] u;
    sub = f[4] | (f[0] & f[1]);
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    s  = sub ? sa - sb : sa + sb;
    v  = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    if (sub) c = (a >= b);
    else begin
      u = {1'b0, a} + {1'b0, b};
      c = u[32];
    end
    if (f[0] && !f[1])      r = s[31:0];
    else if (f[0] && f[1])  r = {31'b0, f[2] ? (a < b) : ($signed(a) < $signed(b))};
    else if (f[1]) begin
      case (f[3:2])
        2'b01:   r = b >> a[4:0];
        2'b11:   r = $signed(b) >>> a[4:0];
        default: r = b << a[4:0];
      endcase
    end else begin
      case (f[3:2])
        2'b00:   r = a & b;
        2'b01:   r = a | b;
        2'b10:   r = a ^ b;
        default: r = ~(a | b);
      endcase
    end
  endfunction

  function automatic string tag(input logic [4:0] f);
    if (f[0] && f[1]) return "R7";
    if (f[0]) return f[4] ? "R3" : "R2";
    if (f[1]) return "R6";
    return "R5";
  endfunction

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [4:0] f);
    logic [31:0] er;
    logic ev, ec;
    @(posedge clk);
    #1;
    op_a = a; op_b = b; fn = f;
    @(negedge clk);
    model(a, b, f, er, ev, ec);
    checks++;
    if (result !== er) begin
      failures++;
      $display("FAIL %s R1 fn=%b a=%h b=%h result=%h expected=%h", tag(f), f, a, b, result, er);
    end
    checks++;
    if ({flag_n, flag_z} !== {er[31], er == 32'd0}) begin
      failures++;
      $display("FAIL R8 fn=%b nz=%b%b expected=%b%b", f, flag_n, flag_z, er[31], er == 32'd0);
    end
    checks++;
    if ({flag_v, flag_c} !== {ev, ec}) begin
      failures++;
      $display("FAIL R4/R9 fn=%b a=%h b=%h vc=%b%b expected=%b%b", f, a, b, flag_v, flag_c, ev, ec);
    end
  endtask

  function automatic logic [31:0] pick(input int k);
    case (k % 8)
      0: return 32'h7FFF_FFFF;
      1: return 32'h8000_0000;
      2: return 32'hFFFF_FFFF;
      3: return 32'h0000_0000;
      4: return 32'h0000_0001;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    rst_n = 0; op_a = '0; op_b = '0; fn = '0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    // Idle state: zero operands, AND selected.
    apply(32'h0, 32'h0, 5'b00000);
    // R2 add with carry and signed overflow
    apply(32'hFFFF_FFFF, 32'h1, 5'b00001);
    apply(32'h7FFF_FFFF, 32'h1, 5'b00001);
    // R3 subtract borrow, equal, overflow
    apply(32'h1, 32'h2, 5'b10001);
    apply(32'h1234_5678, 32'h1234_5678, 5'b10001);
    apply(32'h8000_0000, 32'h1, 5'b10001);
    // R5 logic ops, subtract bit ignored
    for (int s = 0; s < 4; s++) begin
      apply(32'hF0F0_A5A5, 32'hFF00_3C3C, {1'b0, 2'(s), 2'b00});
      apply(32'hF0F0_A5A5, 32'hFF00_3C3C, {1'b1, 2'(s), 2'b00});
    end
    // R6 shifts: upper count bits ignored, extremes
    apply(32'hFFFF_FFE4, 32'h8000_0F01, 5'b00010);
    apply(32'h0000_0024, 32'h8000_0F01, 5'b00110);
    apply(32'h0000_001F, 32'h8000_0000, 5'b01110);
    apply(32'h0000_0020, 32'hDEAD_BEEF, 5'b01110);
    apply(32'h0000_0008, 32'h1234_5678, 5'b01010);
    // R7 compares: signed vs unsigned disagree, sub bit ignored
    apply(32'hFFFF_FFFF, 32'h1, 5'b00011);
    apply(32'hFFFF_FFFF, 32'h1, 5'b00111);
    apply(32'h8000_0000, 32'h7FFF_FFFF, 5'b10011);
    apply(32'h5, 32'h5, 5'b10111);
    // Sweep every function code with boundary and random operands (R1, R4, R9)
    for (int i = 0; i < 3000; i++) begin
      apply(pick(i), pick(i / 8 + i), 5'(i % 32));
    end
    done = 1;
  end

  initial begin
    for (int w = 0; w < 150000; w++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule